// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits between an inbound write port and a CPU. When a device issues a write that lands on the programmed 64-bit doorbell address, the block reads the data word as a vector index and raises a pending flag for that vector. There are thirty-two flags in all. Software reads the flags and clears them by writing ones. It gates each vector with an enable mask and arms or disarms capture with the low bit of the target-low word.

The block has one interrupt output. It merges the enabled pending vectors with up to four level-sensitive legacy interrupt lines, each of which has its own enable. The output is registered. When the flag register reads zero while the interrupt is high, the interrupt comes from a legacy line.

The CPU port is a single-cycle register bus. A write takes effect on the clock edge where `csr_valid` and `csr_write` are both high. Read data is combinational from the selected word.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low.
- R2: Register word offsets are 0 for pending flags, 1 for vector enables, 2 for target-low, 3 for target-high and 4 for legacy control. Offsets 5 to 7 read zero. The enable, target-low and target-high words read back what was written, and writing all ones to word 1 enables all 32 vectors.
- R3: An inbound write sets flag N when four conditions hold: target-low bit 0 is 1, the write address bits 63:32 equal target-high, bits 31:1 equal target-low bits 31:1, and enable bit N is 1. N is the data value, in the range 0 to 31. Address bit 0 plays no part in the match.
- R4: A difference in any single address bit from 1 to 63 means the write sets no flag.
- R5: While target-low bit 0 is 0, inbound writes set no flag.
- R6: A write to a vector whose enable bit is 0 sets no flag.
- R7: A data value of 32 or more sets no flag.
- R8: Writing word 0 clears each flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R9: If a capture and a clear hit the same vector in the same cycle, the flag ends up set.
- R10: `irq_out` is a register. One cycle after the inputs change, it equals the OR of (pending AND enable) over all vectors, ORed with the enabled legacy lines. A pending flag whose enable is 0 stays readable but does not drive the interrupt.
- R11: The legacy enables are bits 11:8 of word 4. Bit 8 gates `intx_req[0]` and bit 11 gates `intx_req[3]`. The other bits of word 4 are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | Register access strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 3 | Register word offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| msi_wr_valid | input | 1 | Inbound write strobe |
| msi_wr_addr | input | 64 | Inbound write address |
| msi_wr_data | input | 32 | Inbound write data (vector index) |
| intx_req | input | 4 | Legacy level interrupt lines A to D |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The bench captures every vector in turn, then flips each address bit one at a time. A design that included bit 0 in the match, or that ignored some upper bit, would fail these sweeps. It also sends data values of 32 and above. A design that decoded only the low five bits would alias them onto low vectors. It drives a capture and a clear to the same vector in one cycle; if the clear won, the interrupt would be lost. Finally it sweeps all sixteen legacy input patterns against all sixteen enable patterns, and checks that `irq_out` lags by exactly one cycle. A combinational output, or an enable field at the wrong bit position, shows up there.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int unsigned TGT_W      = 64;
    localparam int unsigned REG_FLAGS  = 0;
    localparam int unsigned REG_VEC_EN = 1;
    localparam int unsigned REG_TGT_LO = 2;
    localparam int unsigned REG_TGT_HI = 3;
    localparam int unsigned REG_INTX   = 4;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } msi_target_t;

endpackage

// File: rtl/msi_cap_csr.sv
module msi_cap_csr #(
    parameter int unsigned NUM_VEC  = 32,
    parameter int unsigned NUM_INTX = 4,
    parameter int unsigned INTX_LSB = 8,
    parameter int unsigned CSR_AW   = 3,
    parameter int unsigned DW       = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csr_valid,
    input  logic                        csr_write,
    input  logic [CSR_AW-1:0]           csr_addr,
    input  logic [DW-1:0]               csr_wdata,
    input  logic [NUM_VEC-1:0]          flags_i,
    output logic [DW-1:0]               csr_rdata,
    output logic [NUM_VEC-1:0]          vec_en_o,
    output msi_cap_pkg::msi_target_t    target_o,
    output logic                        cap_en_o,
    output logic [NUM_INTX-1:0]         intx_en_o,
    output logic [NUM_VEC-1:0]          clr_o
);
    import msi_cap_pkg::*;

    typedef struct packed {
        logic [NUM_VEC-1:0]  vec_en;
        msi_target_t         tgt;
        logic [NUM_INTX-1:0] intx_en;
    } csr_state_t;

    csr_state_t state_d, state_q;
    logic       wr_en;

    always_comb begin
        state_d   = state_q;
        wr_en     = csr_valid && csr_write;
        clr_o     = '0;
        csr_rdata = '0;

        if (wr_en) begin
            case (csr_addr)
                CSR_AW'(REG_FLAGS):  clr_o          = csr_wdata[NUM_VEC-1:0];
                CSR_AW'(REG_VEC_EN): state_d.vec_en = csr_wdata[NUM_VEC-1:0];
                CSR_AW'(REG_TGT_LO): state_d.tgt.lo = csr_wdata;
                CSR_AW'(REG_TGT_HI): state_d.tgt.hi = csr_wdata;
                CSR_AW'(REG_INTX):   state_d.intx_en = csr_wdata[INTX_LSB +: NUM_INTX];
                default: ;
            endcase
        end

        case (csr_addr)
            CSR_AW'(REG_FLAGS):  csr_rdata[NUM_VEC-1:0] = flags_i;
            CSR_AW'(REG_VEC_EN): csr_rdata[NUM_VEC-1:0] = state_q.vec_en;
            CSR_AW'(REG_TGT_LO): csr_rdata = state_q.tgt.lo;
            CSR_AW'(REG_TGT_HI): csr_rdata = state_q.tgt.hi;
            CSR_AW'(REG_INTX):   csr_rdata[INTX_LSB +: NUM_INTX] = state_q.intx_en;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign vec_en_o  = state_q.vec_en;
    assign target_o  = state_q.tgt;
    assign cap_en_o  = state_q.tgt.lo[0];
    assign intx_en_o = state_q.intx_en;

endmodule

// File: rtl/msi_cap_match.sv
module msi_cap_match #(
    parameter int unsigned NUM_VEC = 32,
    parameter int unsigned DW      = 32
) (
    input  logic                                in_valid,
    input  logic [msi_cap_pkg::TGT_W-1:0]       in_addr,
    input  logic [DW-1:0]                       in_data,
    input  msi_cap_pkg::msi_target_t            target,
    input  logic [NUM_VEC-1:0]                  vec_en,
    output logic [NUM_VEC-1:0]                  set_o
);
    localparam int unsigned IDX_W = $clog2(NUM_VEC);

    logic addr_hit;
    logic range_ok;
    logic accept;

    always_comb begin
        addr_hit = target.lo[0]
                && (in_addr[63:32] == target.hi)
                && (in_addr[31:1]  == target.lo[31:1]);
        range_ok = (in_data < DW'(NUM_VEC));
        accept   = in_valid && addr_hit && range_ok;
    end

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        assign set_o[i] = accept && vec_en[i]
                       && (in_data[IDX_W-1:0] == IDX_W'(i));
    end

endmodule

// File: rtl/msi_cap_flags.sv
module msi_cap_flags #(
    parameter int unsigned NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_i,
    input  logic [NUM_VEC-1:0] clr_i,
    output logic [NUM_VEC-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
    } flag_state_t;

    flag_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.pend = (state_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pend_o = state_q.pend;

endmodule

// File: rtl/msi_cap_irq.sv
module msi_cap_irq #(
    parameter int unsigned NUM_VEC  = 32,
    parameter int unsigned NUM_INTX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_VEC-1:0]  pend_i,
    input  logic [NUM_VEC-1:0]  vec_en_i,
    input  logic [NUM_INTX-1:0] intx_i,
    input  logic [NUM_INTX-1:0] intx_en_i,
    output logic                irq_o
);
    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.irq = (|(pend_i & vec_en_i)) || (|(intx_i & intx_en_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq_o = state_q.irq;

endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl #(
    parameter int unsigned NUM_VEC  = 32,
    parameter int unsigned NUM_INTX = 4,
    parameter int unsigned INTX_LSB = 8,
    parameter int unsigned CSR_AW   = 3,
    parameter int unsigned DW       = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              csr_valid,
    input  logic                              csr_write,
    input  logic [CSR_AW-1:0]                 csr_addr,
    input  logic [DW-1:0]                     csr_wdata,
    output logic [DW-1:0]                     csr_rdata,
    input  logic                              msi_wr_valid,
    input  logic [msi_cap_pkg::TGT_W-1:0]     msi_wr_addr,
    input  logic [DW-1:0]                     msi_wr_data,
    input  logic [NUM_INTX-1:0]               intx_req,
    output logic                              irq_out
);
    msi_cap_pkg::msi_target_t target;
    logic [NUM_VEC-1:0]       vec_en;
    logic [NUM_VEC-1:0]       set_vec;
    logic [NUM_VEC-1:0]       clr_vec;
    logic [NUM_VEC-1:0]       flags_q;
    logic [NUM_INTX-1:0]      intx_en;
    logic                     cap_en;

    msi_cap_csr #(
        .NUM_VEC(NUM_VEC), .NUM_INTX(NUM_INTX), .INTX_LSB(INTX_LSB),
        .CSR_AW(CSR_AW), .DW(DW)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_valid (csr_valid),
        .csr_write (csr_write),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .flags_i   (flags_q),
        .csr_rdata (csr_rdata),
        .vec_en_o  (vec_en),
        .target_o  (target),
        .cap_en_o  (cap_en),
        .intx_en_o (intx_en),
        .clr_o     (clr_vec)
    );

    msi_cap_match #(.NUM_VEC(NUM_VEC), .DW(DW)) u_match (
        .in_valid (msi_wr_valid),
        .in_addr  (msi_wr_addr),
        .in_data  (msi_wr_data),
        .target   (target),
        .vec_en   (vec_en),
        .set_o    (set_vec)
    );

    msi_cap_flags #(.NUM_VEC(NUM_VEC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (flags_q)
    );

    msi_cap_irq #(.NUM_VEC(NUM_VEC), .NUM_INTX(NUM_INTX)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (flags_q),
        .vec_en_i  (vec_en),
        .intx_i    (intx_req),
        .intx_en_i (intx_en),
        .irq_o     (irq_out)
    );

endmodule

// File: rtl/msi_capture_ctrl_chk.sv
module msi_capture_ctrl_chk #(
    parameter int unsigned NUM_VEC  = 32,
    parameter int unsigned NUM_INTX = 4,
    parameter int unsigned DW       = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_VEC-1:0]  set_vec,
    input logic [NUM_VEC-1:0]  clr_vec,
    input logic [NUM_VEC-1:0]  flags_q,
    input logic [NUM_VEC-1:0]  vec_en,
    input logic                cap_en,
    input logic [DW-1:0]       in_data,
    input logic [NUM_INTX-1:0] intx_req,
    input logic [NUM_INTX-1:0] intx_en,
    input logic                irq_out
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R3
    capture_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

    // R3
    single_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

    // R5
    capture_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |-> (set_vec == '0));

    // R6
    masked_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & ~vec_en) == '0));

    // R7
    data_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data >= DW'(NUM_VEC)) |-> (set_vec == '0));

    // R8
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));

    // R10
    irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (irq_out == $past((|(flags_q & vec_en)) || (|(intx_req & intx_en)))));

endmodule

bind msi_capture_ctrl msi_capture_ctrl_chk #(
    .NUM_VEC(NUM_VEC), .NUM_INTX(NUM_INTX), .DW(DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .flags_q  (flags_q),
    .vec_en   (vec_en),
    .cap_en   (cap_en),
    .in_data  (msi_wr_data),
    .intx_req (intx_req),
    .intx_en  (intx_en),
    .irq_out  (irq_out)
);

// File: tb/msi_capture_ctrl_bench.sv
module msi_capture_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic        csr_write = 1'b0;
    logic [2:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        msi_wr_valid = 1'b0;
    logic [63:0] msi_wr_addr = '0;
    logic [31:0] msi_wr_data = '0;
    logic [3:0]  intx_req = '0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;

    localparam logic [63:0] TGT = 64'h9E37_1B04_C0DE_5A40;

    always #4 clk = ~clk;

    msi_capture_ctrl u_msi_capture_ctrl (
        .clk(clk), .rst_n(rst_n),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .msi_wr_valid(msi_wr_valid), .msi_wr_addr(msi_wr_addr),
        .msi_wr_data(msi_wr_data), .intx_req(intx_req), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_valid = 1'b0; csr_write = 1'b0;
    endtask

    task automatic csr_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = 1'b0; csr_addr = a;
        #1 d = csr_rdata;
        csr_valid = 1'b0;
    endtask

    task automatic inb(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        msi_wr_valid = 1'b1; msi_wr_addr = a; msi_wr_data = d;
        @(negedge clk);
        msi_wr_valid = 1'b0;
    endtask

    task automatic expect_flags(input string req, input logic [31:0] exp);
        logic [31:0] rd;
        csr_rd(3'd0, rd);
        chk(req, {32'h0, rd}, {32'h0, exp});
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            csr_rd(3'(a), rd);
            chk("R1", {32'h0, rd}, 64'h0);
        end
        chk("R1 irq", {63'h0, irq_out}, 64'h0);

        // R2 register map and readback
        csr_wr(3'd1, 32'hFFFF_FFFF);
        csr_rd(3'd1, rd); chk("R2 vec_en", {32'h0, rd}, 64'hFFFF_FFFF);
        csr_wr(3'd3, TGT[63:32]);
        csr_rd(3'd3, rd); chk("R2 tgt_hi", {32'h0, rd}, {32'h0, TGT[63:32]});
        csr_wr(3'd2, TGT[31:0] | 32'h1);
        csr_rd(3'd2, rd); chk("R2 tgt_lo", {32'h0, rd}, {32'h0, TGT[31:0] | 32'h1});
        for (int a = 5; a < 8; a++) begin
            csr_rd(3'(a), rd);
            chk("R2 unmapped", {32'h0, rd}, 64'h0);
        end

        // R11 legacy enable field position
        csr_wr(3'd4, 32'hFFFF_FFFF);
        csr_rd(3'd4, rd); chk("R11 field", {32'h0, rd}, 64'h0000_0F00);
        csr_wr(3'd4, 32'h0);

        // R3 / R8 / R10 sweep every vector
        for (int v = 0; v < 32; v++) begin
            inb(TGT, 32'(v));
            chk("R10 latency", {63'h0, irq_out}, 64'h0);
            @(negedge clk);
            chk("R10 assert", {63'h0, irq_out}, 64'h1);
            expect_flags("R3", 32'h1 << v);
            csr_wr(3'd0, 32'h1 << v);
            expect_flags("R8 clear", 32'h0);
            @(negedge clk);
            chk("R10 deassert", {63'h0, irq_out}, 64'h0);
        end

        // R8 writing zeros leaves flags alone
        inb(TGT, 32'd3);
        inb(TGT, 32'd7);
        csr_wr(3'd0, 32'h0);
        expect_flags("R8 zero", 32'h88);
        csr_wr(3'd0, 32'h8);
        expect_flags("R8 partial", 32'h80);
        csr_wr(3'd0, 32'hFFFF_FFFF);
        expect_flags("R8 all", 32'h0);

        // R7 out-of-range data
        for (int d = 32; d < 72; d++) begin
            inb(TGT, 32'(d));
            expect_flags("R7", 32'h0);
        end
        inb(TGT, 32'hFFFF_FFFF); expect_flags("R7 max", 32'h0);
        inb(TGT, 32'h0001_0004); expect_flags("R7 high", 32'h0);

        // R4 single-bit address differences, bit 0 ignored
        for (int b = 1; b < 64; b++) begin
            inb(TGT ^ (64'h1 << b), 32'd5);
            expect_flags("R4", 32'h0);
        end
        inb(TGT | 64'h1, 32'd5);
        expect_flags("R3 bit0", 32'h20);
        csr_wr(3'd0, 32'h20);

        // R5 capture disabled
        csr_wr(3'd2, TGT[31:0]);
        inb(TGT, 32'd6);
        inb(TGT | 64'h1, 32'd6);
        expect_flags("R5", 32'h0);
        csr_wr(3'd2, TGT[31:0] | 32'h1);

        // R6 disabled vector
        csr_wr(3'd1, ~(32'h1 << 9));
        inb(TGT, 32'd9);
        expect_flags("R6", 32'h0);
        inb(TGT, 32'd10);
        expect_flags("R6 other", 32'h400);
        // R10 masked pending flag stays but irq drops
        csr_wr(3'd1, ~(32'h1 << 10));
        @(negedge clk);
        chk("R10 masked", {63'h0, irq_out}, 64'h0);
        expect_flags("R10 masked flag", 32'h400);
        csr_wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R10 unmasked", {63'h0, irq_out}, 64'h1);
        csr_wr(3'd0, 32'h400);

        // R9 set wins over clear in same cycle
        inb(TGT, 32'd12);
        @(negedge clk);
        msi_wr_valid = 1'b1; msi_wr_addr = TGT; msi_wr_data = 32'd12;
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = 3'd0; csr_wdata = 32'h1000;
        @(negedge clk);
        msi_wr_valid = 1'b0; csr_valid = 1'b0; csr_write = 1'b0;
        expect_flags("R9 same", 32'h1000);
        @(negedge clk);
        msi_wr_valid = 1'b1; msi_wr_data = 32'd13;
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = 3'd0; csr_wdata = 32'h1000;
        @(negedge clk);
        msi_wr_valid = 1'b0; csr_valid = 1'b0; csr_write = 1'b0;
        expect_flags("R9 other", 32'h2000);
        csr_wr(3'd0, 32'hFFFF_FFFF);

        // R11 / R10 legacy sweep
        for (int en = 0; en < 16; en++) begin
            csr_wr(3'd4, 32'(en) << 8);
            for (int rq = 0; rq < 16; rq++) begin
                @(negedge clk);
                intx_req = 4'(rq);
                @(negedge clk);
                chk("R11 intx", {63'h0, irq_out}, {63'h0, |(4'(rq) & 4'(en))});
            end
        end
        intx_req = '0;
        expect_flags("R10 intx only", 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule